// File: doc/BRIEF.md
# Virtual Hierarchy Next-Hop Router

This block sits beside a core and decides where a miss in the core's private caches goes next. Each request carries a hierarchy number, supplied by the address translation stage, and a line address. The block holds one entry per hierarchy number. An entry says whether the hierarchy is in use, whether it has one or two virtual levels, and, for each level, a short list of bank IDs. The most significant bit of each bank ID says whether that bank is SRAM (0) or DRAM (1). A level may freely mix both kinds of bank. The bank within a level is picked by an XOR-fold of the line address, so a given line always lands in the same slot.

A fresh miss is sent to the first-level bank. If that bank misses, the requester asks again with the hop it just tried and a miss flag. The block then names the second-level bank, or main memory when there is no second level. A second-level miss goes to memory. A hit, or a reply from memory, ends the path. Software rewrites entries through a plain write port whenever it reshapes the hierarchies. A write is seen by lookups from the next cycle on.

Top module: `vh_route_table`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every entry is invalid.
- R2: A fresh request (`req_follow`=0) to a valid entry answers hop code 0 (level 1). The bank is the level-1 slot chosen by the hash, passed through unchanged including its top SRAM/DRAM bit.
- R3: The slot index is the XOR-fold of the line address. Line bit i toggles index bit (i mod log2(SLOTS)). Two lines with equal folds map to the same slot.
- R4: A follow-up with hop 0 and `req_miss`=1 to a valid two-level entry answers hop code 1 (level 2). The bank is the level-2 slot chosen by the same hash.
- R5: A follow-up with hop 0 and a miss, to a valid single-level entry, answers hop code 2 (memory) with bank 0.
- R6: A follow-up with hop 1 and a miss answers hop code 2 with bank 0.
- R7: A follow-up with `req_miss`=0, or one carrying hop 2 or 3, answers hop code 3 (done) with bank 0.
- R8: A fresh request, or a level-1 miss follow-up, to an invalid entry answers hop code 2 with bank 0.
- R9: A table write affects lookups accepted from the next cycle on. A lookup accepted in the same cycle as the write sees the old contents.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid` on the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | VH_W | Entry written |
| cfg_valid | input | 1 | Entry in use |
| cfg_two | input | 1 | Entry has a second level |
| cfg_l1 | input | SLOTS*BANK_W | Level-1 bank IDs, slot s at bits s*BANK_W upward |
| cfg_l2 | input | SLOTS*BANK_W | Level-2 bank IDs, same packing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_vh | input | VH_W | Hierarchy number |
| req_line | input | LINE_W | Line address |
| req_follow | input | 1 | 1 = follow-up after trying a hop |
| req_hop | input | 2 | Hop just tried (follow-up only) |
| req_miss | input | 1 | That hop missed (follow-up only) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_bank | output | BANK_W | Target bank ID |
| rsp_hop | output | 2 | 0 level 1, 1 level 2, 2 memory, 3 done |

## Verification
Directed lines with chosen bit patterns show the fold itself: single bits land in distinct slots, and bit pairs that cancel fall back to slot 0. This is how the hash is told apart from a plain truncation. Entries with one level, two levels, and no valid bit each receive fresh requests and follow-ups for every hop and miss value, so each path branch gives a different expected answer. A write made in the same cycle as a lookup shows whether the old or the new contents were used. A stalled response shows that values are held. Random entries, lines and follow-ups then run against a bench model of the requirements.

// File: rtl/vh_route_table.sv
module vh_route_table #(
  parameter int NUM_VH = 8,
  parameter int SLOTS  = 8,
  parameter int BANK_W = 6,
  parameter int LINE_W = 26,
  localparam int VH_W   = $clog2(NUM_VH),
  localparam int HW     = $clog2(SLOTS),
  localparam int LIST_W = SLOTS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VH_W-1:0]   cfg_idx,
  input  logic              cfg_valid,
  input  logic              cfg_two,
  input  logic [LIST_W-1:0] cfg_l1,
  input  logic [LIST_W-1:0] cfg_l2,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VH_W-1:0]   req_vh,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_follow,
  input  logic [1:0]        req_hop,
  input  logic              req_miss,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [1:0]        rsp_hop
);
  localparam logic [1:0] HOP_L1 = 2'd0, HOP_L2 = 2'd1, HOP_MEM = 2'd2, HOP_DONE = 2'd3;

  logic [NUM_VH-1:0] ent_valid, ent_two;
  logic [LIST_W-1:0] l1_list [NUM_VH];
  logic [LIST_W-1:0] l2_list [NUM_VH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_two   <= '0;
    end else if (cfg_we) begin
      ent_valid[cfg_idx] <= cfg_valid;
      ent_two[cfg_idx]   <= cfg_two;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      l1_list[cfg_idx] <= cfg_l1;
      l2_list[cfg_idx] <= cfg_l2;
    end
  end

  logic [HW-1:0] slot;
  always_comb begin
    slot = '0;
    for (int i = 0; i < LINE_W; i++) slot[i % HW] = slot[i % HW] ^ req_line[i];
  end

  logic [LIST_W-1:0] sel_l1, sel_l2;
  logic [BANK_W-1:0] l1_bank, l2_bank;
  assign sel_l1 = l1_list[req_vh];
  assign sel_l2 = l2_list[req_vh];

  always_comb begin
    l1_bank = '0;
    l2_bank = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot == s[HW-1:0]) begin
        l1_bank = sel_l1[s*BANK_W +: BANK_W];
        l2_bank = sel_l2[s*BANK_W +: BANK_W];
      end
    end
  end

  logic              e_valid, e_two;
  logic [1:0]        nxt_hop;
  logic [BANK_W-1:0] nxt_bank;
  assign e_valid = ent_valid[req_vh];
  assign e_two   = ent_two[req_vh];

  always_comb begin
    nxt_hop  = HOP_DONE;
    nxt_bank = '0;
    if (!req_follow) begin
      if (e_valid) begin
        nxt_hop  = HOP_L1;
        nxt_bank = l1_bank;
      end else begin
        nxt_hop  = HOP_MEM;
      end
    end else if (req_miss) begin
      case (req_hop)
        HOP_L1: begin
          if (e_valid && e_two) begin
            nxt_hop  = HOP_L2;
            nxt_bank = l2_bank;
          end else begin
            nxt_hop  = HOP_MEM;
          end
        end
        HOP_L2:  nxt_hop = HOP_MEM;
        default: nxt_hop = HOP_DONE;
      endcase
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bank  <= '0;
      rsp_hop   <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_bank <= nxt_bank;
        rsp_hop  <= nxt_hop;
      end
    end
  end
endmodule

// File: rtl/vh_route_table_chk.sv
module vh_route_table_chk #(
  parameter int BANK_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_follow,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BANK_W-1:0] rsp_bank,
  input logic [1:0]        rsp_hop
);
  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bank) && $stable(rsp_hop));

  // R10
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !$past(rsp_valid) |-> $past(req_valid && req_ready));

  // R7
  done_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hop == 2'd3 |-> rsp_bank == '0);

  // R5
  mem_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hop == 2'd2 |-> rsp_bank == '0);

  // R2
  fresh_first_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_follow |=> rsp_hop == 2'd0 || rsp_hop == 2'd2);
endmodule

bind vh_route_table vh_route_table_chk #(.BANK_W(BANK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_follow(req_follow), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_bank(rsp_bank), .rsp_hop(rsp_hop)
);

// File: tb/vh_route_table_tb.sv
module vh_route_table_tb_top;
  localparam int NUM_VH = 8, SLOTS = 8, BANK_W = 6, LINE_W = 26;
  localparam int VH_W = 3, HW = 3, LIST_W = SLOTS * BANK_W;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_valid = 0, cfg_two = 0;
  logic [VH_W-1:0] cfg_idx = '0;
  logic [LIST_W-1:0] cfg_l1 = '0, cfg_l2 = '0;
  logic req_valid = 0, req_follow = 0, req_miss = 0, rsp_ready = 1;
  logic [VH_W-1:0] req_vh = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic [1:0] req_hop = '0;
  logic req_ready, rsp_valid;
  logic [BANK_W-1:0] rsp_bank;
  logic [1:0] rsp_hop;

  int tests = 0, fails = 0;
  logic m_valid [NUM_VH];
  logic m_two [NUM_VH];
  logic [LIST_W-1:0] m_l1 [NUM_VH];
  logic [LIST_W-1:0] m_l2 [NUM_VH];

  always #2 clk = ~clk;

  vh_route_table dut_i (.*);

  function automatic logic [HW-1:0] fold(input logic [LINE_W-1:0] a);
    logic [HW-1:0] h = '0;
    for (int i = 0; i < LINE_W; i++) if (a[i]) h[i % HW] = ~h[i % HW];
    return h;
  endfunction

  function automatic logic [BANK_W+1:0] expect_fn(input logic [VH_W-1:0] vh,
      input logic [LINE_W-1:0] ln, input logic fol, input logic [1:0] hp, input logic ms);
    int s = int'(fold(ln));
    if (!fol) begin
      if (m_valid[vh]) return {2'd0, m_l1[vh][s*BANK_W +: BANK_W]};
      return {2'd2, {BANK_W{1'b0}}};
    end
    if (!ms || hp[1]) return {2'd3, {BANK_W{1'b0}}};
    if (hp == 2'd0 && m_valid[vh] && m_two[vh]) return {2'd1, m_l2[vh][s*BANK_W +: BANK_W]};
    return {2'd2, {BANK_W{1'b0}}};
  endfunction

  task automatic check(input string req, input logic [BANK_W+1:0] got, input logic [BANK_W+1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got hop=%0d bank=%0h, expected hop=%0d bank=%0h",
               req, got[BANK_W+1:BANK_W], got[BANK_W-1:0], exp[BANK_W+1:BANK_W], exp[BANK_W-1:0]);
    end
  endtask

  task automatic wr(input int idx, input logic v, input logic two,
                    input logic [LIST_W-1:0] a, input logic [LIST_W-1:0] b);
    @(negedge clk);
    cfg_we = 1; cfg_idx = VH_W'(idx); cfg_valid = v; cfg_two = two; cfg_l1 = a; cfg_l2 = b;
    @(negedge clk);
    cfg_we = 0;
    m_valid[idx] = v; m_two[idx] = two; m_l1[idx] = a; m_l2[idx] = b;
  endtask

  task automatic look(input string req, input int vh, input logic [LINE_W-1:0] ln,
                      input logic fol, input logic [1:0] hp, input logic ms);
    logic [BANK_W+1:0] e;
    e = expect_fn(VH_W'(vh), ln, fol, hp, ms);
    @(negedge clk);
    req_valid = 1; req_vh = VH_W'(vh); req_line = ln; req_follow = fol; req_hop = hp; req_miss = ms;
    @(negedge clk);
    req_valid = 0;
    check(req, {rsp_hop, rsp_bank}, e);
  endtask

  function automatic logic [LIST_W-1:0] seq_list(input int base);
    logic [LIST_W-1:0] l;
    for (int s = 0; s < SLOTS; s++) l[s*BANK_W +: BANK_W] = BANK_W'(base + s);
    return l;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [BANK_W+1:0] e_old, e_new, e_a, e_b;
    void'($urandom(32'd9041));
    for (int i = 0; i < NUM_VH; i++) begin
      m_valid[i] = 0; m_two[i] = 0; m_l1[i] = '0; m_l2[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: got rsp_valid=%0b req_ready=%0b, expected 0 1", rsp_valid, req_ready);
    end
    look("R1 entry invalid after reset", 0, 26'h5, 0, 0, 0);
    look("R8 invalid fresh", 3, 26'h1234, 0, 0, 0);

    // SRAM banks 0x08.., DRAM banks 0x28.. (top bit set) mixed in one level
    wr(0, 1, 1, seq_list(8) | {SLOTS{6'h20}} & 48'hFFF000FFF000, seq_list(16));
    wr(1, 1, 0, seq_list(40), seq_list(50));
    look("R2 slot0", 0, 26'h0, 0, 0, 0);
    look("R2 R3 bit3->slot1", 0, 26'h8, 0, 0, 0);
    look("R3 bit1->slot2", 0, 26'h2, 0, 0, 0);
    look("R3 slot7", 0, 26'h7, 0, 0, 0);
    look("R3 bits0,3 cancel", 0, 26'h9, 0, 0, 0);
    look("R3 high bit 25->slot2", 0, 26'h2000000, 0, 0, 0);
    look("R4 l1 miss two-level", 0, 26'h5, 1, 0, 1);
    look("R5 l1 miss single-level", 1, 26'h5, 1, 0, 1);
    look("R6 l2 miss", 0, 26'h5, 1, 1, 1);
    look("R7 l1 hit", 0, 26'h5, 1, 0, 0);
    look("R7 l2 hit", 0, 26'h5, 1, 1, 0);
    look("R7 from memory", 0, 26'h5, 1, 2, 1);
    look("R7 hop3", 0, 26'h5, 1, 3, 1);
    look("R8 invalid l1 miss", 4, 26'h5, 1, 0, 1);

    // R9: write and lookup in the same cycle
    e_old = expect_fn(3'd1, 26'h3, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd1; cfg_valid = 1; cfg_two = 1; cfg_l1 = seq_list(2); cfg_l2 = seq_list(30);
    req_valid = 1; req_vh = 3'd1; req_line = 26'h3; req_follow = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R9 same-cycle sees old", {rsp_hop, rsp_bank}, e_old);
    m_valid[1] = 1; m_two[1] = 1; m_l1[1] = seq_list(2); m_l2[1] = seq_list(30);
    e_new = expect_fn(3'd1, 26'h3, 0, 0, 0);
    look("R9 next cycle sees new", 1, 26'h3, 0, 0, 0);
    look("R9 new second level", 1, 26'h3, 1, 0, 1);
    if (e_new == e_old) $display("note: R9 directed values coincide");

    // R10: stall holds the response
    e_a = expect_fn(3'd0, 26'h1, 0, 0, 0);
    e_b = expect_fn(3'd0, 26'h1, 1, 0, 1);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vh = 0; req_line = 26'h1; req_follow = 0;
    @(negedge clk);
    req_follow = 1; req_hop = 0; req_miss = 1;
    tests++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R10: got req_ready=%0b, expected 0", req_ready);
    end
    repeat (2) @(negedge clk);
    check("R10 held while stalled", {rsp_hop, rsp_bank}, e_a);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R10 next after release", {rsp_hop, rsp_bank}, e_b);
    @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: got rsp_valid=%0b, expected 0", rsp_valid);
    end

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 7) == 0)
        wr($urandom_range(0, NUM_VH-1), 1'($urandom_range(0, 3) != 0), 1'($urandom),
           LIST_W'({$urandom(), $urandom()}), LIST_W'({$urandom(), $urandom()}));
      look("R2 R3 R4 R5 R6 R7 R8 random", $urandom_range(0, NUM_VH-1), LINE_W'($urandom),
           1'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule